// File: doc/BRIEF.md
# Serial Flash Write-Protection Gate

This block decides whether a modifying command may reach the array of a serial NOR flash. It holds the protection fields of the status register: a status-lock bit, a top/bottom select bit and a 3-bit protect level. It also holds the write-enable latch and samples the active-low write-protect pin. Upstream logic has already decoded a command and its target address. It presents them for one cycle. One cycle later the gate answers with a single-cycle accept or reject pulse.

Two things combine to block a status write: the status-lock bit and the pin level. When both are asserted the device is in hardware-protected mode. It does not matter which of the two was asserted first, and only raising the pin ends this mode. The protect level and the top/bottom bit define a protected range of 64 KB blocks. Program and erase commands that target that range are refused. A chip erase is refused whenever any range is protected.

Top module: `flash_wp_gate`

## Requirements
- R1: After reset all of the following are 0: srwd, tb, bp, wel, hpm, accept and reject.
- R2: Opcode 0 sets wel and opcode 1 clears it. Neither produces an accept or a reject pulse.
- R3: Opcodes 2 to 7 are rejected when wel is 0.
- R4: A status write (opcode 2) with wel set and srwd 0 is accepted whatever the pin level. It loads srwd from sr_wdata[4], tb from sr_wdata[3] and bp from sr_wdata[2:0].
- R5: A status write with wel set, srwd 1 and the sampled pin high is accepted and loads the fields.
- R6: hpm is 1 exactly when srwd is 1 and the pin sampled at the previous clock edge is low, whichever became true first. In that state a status write is rejected and srwd, tb and bp keep their values.
- R7: Once hpm is 1 it returns to 0 only after the pin has been sampled high.
- R8: The protected range covers no blocks for bp=0, 2^(bp-1) blocks of 64 KB for bp from 1 to 6 (limited to the array size), and the whole array for bp=7. The range sits at the top of the address space when tb=0 and at the bottom when tb=1.
- R9: Page program (3), dual-input program (4), sector erase (5) and block erase (6) are rejected when the address falls in the protected range and accepted otherwise, given that wel is set.
- R10: Chip erase (7) is rejected when bp is not 0 and accepted when bp is 0, given that wel is set.
- R11: After any command with opcode 2 to 7, whether accepted or rejected, wel is 0.
- R12: accept or reject pulses for one cycle, on the clock after the command. The two are never high together, and neither is high without a command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wp_n | input | 1 | Active-low write-protect pin |
| cmd_valid | input | 1 | Command present this cycle |
| cmd_op | input | 3 | Decoded opcode (0 set latch, 1 clear latch, 2 status write, 3..7 program/erase) |
| cmd_addr | input | ADDR_W | Target byte address |
| sr_wdata | input | 5 | Status write data {lock, tb, bp[2:0]} |
| accept | output | 1 | Command accepted pulse |
| reject | output | 1 | Command rejected pulse |
| hpm | output | 1 | Hardware-protected mode in force |
| wel | output | 1 | Write-enable latch |
| srwd | output | 1 | Status-lock bit |
| tb | output | 1 | Top/bottom select |
| bp | output | 3 | Protect level |

## Verification
The bench enters hardware-protected mode in both orders. A design that looked only at the lock bit, or that latched the mode, would then either accept the locked status write or keep refusing after the pin rises. Addresses are driven at the first and last block of each range edge with tb set both ways, which exposes an off-by-one or inverted region decode. The bench issues chip erase with a nonzero level and repeats commands without a fresh enable. This catches a latch that survives a rejected command.

// File: rtl/flash_wp_gate.sv
module flash_wp_gate #(
  parameter int ADDR_W  = 24,
  parameter int BLOCK_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wp_n,
  input  logic              cmd_valid,
  input  logic [2:0]        cmd_op,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic [4:0]        sr_wdata,
  output logic              accept,
  output logic              reject,
  output logic              hpm,
  output logic              wel,
  output logic              srwd,
  output logic              tb,
  output logic [2:0]        bp
);
  localparam int IDX_W = ADDR_W - BLOCK_W;
  localparam logic [IDX_W:0] FULL = {1'b1, {IDX_W{1'b0}}};
  localparam logic [IDX_W:0] ONE  = {{IDX_W{1'b0}}, 1'b1};
  localparam logic [2:0] OP_SET = 3'd0, OP_CLR = 3'd1, OP_WRSR = 3'd2, OP_CE = 3'd7;

  logic            wp_q;
  logic [IDX_W:0]  span;
  logic [IDX_W:0]  blk;
  logic            in_prot, modifying, ok;

  assign blk = {1'b0, cmd_addr[ADDR_W-1:BLOCK_W]};

  always_comb begin
    if (bp == 3'd0)                                     span = '0;
    else if (bp == 3'd7 || (int'(bp) - 1) >= IDX_W)     span = FULL;
    else                                                span = ONE << (bp - 3'd1);
  end

  assign in_prot   = tb ? (blk < span) : (blk >= (FULL - span));
  assign hpm       = srwd & ~wp_q;
  assign modifying = cmd_op >= OP_WRSR;

  always_comb begin
    if (cmd_op == OP_WRSR)    ok = wel & ~hpm;
    else if (cmd_op == OP_CE) ok = wel & (bp == 3'd0);
    else                      ok = wel & ~in_prot;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      accept <= 1'b0;
      reject <= 1'b0;
      wel    <= 1'b0;
      srwd   <= 1'b0;
      tb     <= 1'b0;
      bp     <= 3'd0;
      wp_q   <= 1'b1;
    end else begin
      wp_q   <= wp_n;
      accept <= cmd_valid & modifying & ok;
      reject <= cmd_valid & modifying & ~ok;
      if (cmd_valid) begin
        if (cmd_op == OP_SET)      wel <= 1'b1;
        else                       wel <= 1'b0;
        if (cmd_op == OP_WRSR && ok) {srwd, tb, bp} <= sr_wdata;
      end
    end
  end
endmodule

module flash_wp_gate_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cmd_valid,
  input logic [2:0] cmd_op,
  input logic [4:0] sr_wdata,
  input logic       wp_q,
  input logic       accept,
  input logic       reject,
  input logic       hpm,
  input logic       wel,
  input logic       srwd,
  input logic       tb,
  input logic [2:0] bp
);
  assert_pulse_exclusive_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !(accept && reject));
  assert_no_enable_reject_R3: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && cmd_op >= 3'd2 && !wel |=> reject);
  assert_latch_cleared_R11: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && cmd_op >= 3'd2 |=> !wel);
  assert_unlocked_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && cmd_op == 3'd2 && wel && !srwd |=> accept && {srwd, tb, bp} == $past(sr_wdata));
  assert_locked_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && cmd_op == 3'd2 && hpm |=> reject && $stable({srwd, tb, bp}));
  assert_hpm_exit_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(hpm) |-> $rose(wp_q));
  assert_chip_erase_R10: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && cmd_op == 3'd7 && bp != 3'd0 |=> reject);
  assert_latch_ops_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && cmd_op < 3'd2 |=> !accept && !reject && (wel == ($past(cmd_op) == 3'd0)));
endmodule

bind flash_wp_gate flash_wp_gate_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op), .sr_wdata(sr_wdata),
  .wp_q(wp_q), .accept(accept), .reject(reject), .hpm(hpm), .wel(wel),
  .srwd(srwd), .tb(tb), .bp(bp)
);

// File: tb/tb_flash_wp_gate.sv
module tb_flash_wp_gate;
  localparam int ADDR_W = 24;
  localparam int BLOCK_W = 16;
  localparam int NBLK = 1 << (ADDR_W - BLOCK_W);

  logic clk = 0, rst_n = 0, wp_n = 1, cmd_valid = 0;
  logic [2:0] cmd_op = 0;
  logic [ADDR_W-1:0] cmd_addr = 0;
  logic [4:0] sr_wdata = 0;
  logic accept, reject, hpm, wel, srwd, tb, bp_dummy;
  logic [2:0] bp;

  int n_cmp = 0, n_bad = 0;
  logic m_wel = 0, m_srwd = 0, m_tb = 0, m_wpq = 1;
  logic [2:0] m_bp = 0;
  logic e_acc, e_rej;

  always #10 clk = ~clk;

  flash_wp_gate #(.ADDR_W(ADDR_W), .BLOCK_W(BLOCK_W)) dut (
    .clk(clk), .rst_n(rst_n), .wp_n(wp_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_addr(cmd_addr), .sr_wdata(sr_wdata), .accept(accept), .reject(reject),
    .hpm(hpm), .wel(wel), .srwd(srwd), .tb(tb), .bp(bp));

  assign bp_dummy = 1'b0;

  function automatic bit prot(input logic [ADDR_W-1:0] a, input logic t, input logic [2:0] l);
    int n, b;
    b = int'(a >> BLOCK_W);
    if (l == 0) n = 0;
    else if (l == 7) n = NBLK;
    else n = ((1 << (l - 1)) > NBLK) ? NBLK : (1 << (l - 1));
    return t ? (b < n) : (b >= NBLK - n);
  endfunction

  function automatic bit allowed(input logic [2:0] op, input logic [ADDR_W-1:0] a);
    if (!m_wel) return 0;
    if (op == 2) return !(m_srwd && !m_wpq);
    if (op == 7) return m_bp == 0;
    return !prot(a, m_tb, m_bp);
  endfunction

  task automatic check(input string tag, input logic [7:0] got, input logic [7:0] exp);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s got=%0h exp=%0h at %0t", tag, got, exp, $time);
    end
  endtask

  task automatic step(input logic v, input logic [2:0] op, input logic [ADDR_W-1:0] a, input logic [4:0] d);
    bit ok;
    cmd_valid = v; cmd_op = op; cmd_addr = a; sr_wdata = d;
    ok = allowed(op, a);
    e_acc = v && op >= 2 && ok;
    e_rej = v && op >= 2 && !ok;
    @(posedge clk);
    if (v) begin
      if (op == 2 && ok) {m_srwd, m_tb, m_bp} = d;
      m_wel = (op == 0);
    end
    m_wpq = wp_n;
    @(negedge clk);
    cmd_valid = 0;
    if (v && op >= 2 && op != 7 && op != 2) begin
      check("R9 accept", {7'd0, accept}, {7'd0, e_acc});
      check("R9 reject", {7'd0, reject}, {7'd0, e_rej});
    end else if (v && op == 7) begin
      check("R10 accept", {7'd0, accept}, {7'd0, e_acc});
      check("R10 reject", {7'd0, reject}, {7'd0, e_rej});
    end else if (v && op == 2) begin
      check("R5 accept", {7'd0, accept}, {7'd0, e_acc});
      check("R3 reject", {7'd0, reject}, {7'd0, e_rej});
    end else
      check("R12 no pulse", {6'd0, accept, reject}, 8'd0);
    check("R6 hpm", {7'd0, hpm}, {7'd0, m_srwd & ~m_wpq});
    check("R11 wel", {7'd0, wel}, {7'd0, m_wel});
    check("R4 status", {3'd0, srwd, tb, bp}, {3'd0, m_srwd, m_tb, m_bp});
  endtask

  initial begin
    #4_000_000;
    n_bad++;
    $display("FAIL watchdog expired");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    logic [ADDR_W-1:0] top;
    top = {ADDR_W{1'b1}};
    void'($urandom(32'd20240611));
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1;
    check("R1 reset", {accept, reject, hpm, wel, srwd, tb, bp}, 8'd0);
    // R2
    step(1, 0, 0, 0);
    step(1, 1, 0, 0);
    step(1, 3, 0, 0);                       // R3 no latch
    step(1, 0, 0, 0); step(1, 2, 0, 5'b00011); // R4 bp=3 top 4 blocks
    step(1, 0, 0, 0); step(1, 3, top, 0);       // R8 top block protected
    step(1, 0, 0, 0); step(1, 5, top - (24'd4 << BLOCK_W), 0);
    step(1, 0, 0, 0); step(1, 6, top - (24'd3 << BLOCK_W), 0);
    step(1, 0, 0, 0); step(1, 4, 0, 0);
    step(1, 0, 0, 0); step(1, 7, 0, 0);         // R10 refused
    step(1, 2, 0, 0);                            // R3
    step(1, 0, 0, 0); step(1, 2, 0, 5'b01010);   // tb=1 bp=2
    step(1, 0, 0, 0); step(1, 3, 24'd1 << BLOCK_W, 0);
    step(1, 0, 0, 0); step(1, 3, 24'd2 << BLOCK_W, 0);
    // R6 order 1: pin low, then lock written (R4 with pin low)
    wp_n = 0; step(0, 0, 0, 0);
    step(1, 0, 0, 0); step(1, 2, 0, 5'b10000);
    step(1, 0, 0, 0); step(1, 2, 0, 5'b00111);   // locked, unchanged
    step(1, 0, 0, 0); step(1, 7, 0, 0);         // R10 bp=0 accept
    wp_n = 1; step(0, 0, 0, 0);                 // R7 exit
    step(1, 0, 0, 0); step(1, 2, 0, 5'b10001);  // R5 pin high, lock set
    // R6 order 2: lock set, then pin low
    wp_n = 0; step(0, 0, 0, 0); step(0, 0, 0, 0);
    step(1, 0, 0, 0); step(1, 2, 0, 5'b00000);
    wp_n = 1; step(0, 0, 0, 0);
    for (int i = 0; i < 1500; i++) begin
      logic [2:0] op;
      int r;
      r = int'($urandom % 16);
      op = (r < 6) ? 3'd0 : 3'(r % 8);
      if ($urandom % 20 == 0) wp_n = ~wp_n;
      step(($urandom % 8) != 0, op, ADDR_W'($urandom), 5'($urandom));
    end
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule